// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps an asynchronous DRAM alive without any help from the access path. After reset it waits a fixed power-up pause. It then runs a burst of dummy refresh cycles, raises a ready flag and from then on issues one CAS-before-RAS refresh per refresh interval. Every refresh is a CAS-before-RAS cycle, so the memory advances its own row pointer and the block drives no address. Write enable and output enable are of no concern to it, and the data pins stay in high impedance.

The sequencer shares the DRAM strobes with an access controller. An external multiplexer picks which of the two drives RAS and CAS. To take the bus the sequencer raises a request and waits for a grant. The arbiter gives the grant only once its own RAS precharge is done. The sequencer drops the request after its own precharge has elapsed, and it waits for the grant to fall before it asks again. If the bus is held for a long time, missed refresh intervals are counted as a small debt and paid back later.

A low-power request received while ready puts the memory into self-refresh: CAS falls, then RAS falls, and both stay low for as long as the request is held. On release the block waits out a longer exit precharge and performs one extra refresh before it reports ready again. All durations are clock-cycle parameters.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, rasN and casN are high (1 = inactive), refReq is low and memReady is low.
- R2: refReq first goes high exactly PWR_WAIT_CYC clock cycles after reset is released, and no strobe moves before it does.
- R3: Once granted, the block performs INIT_REFRESHES refresh cycles back to back. RAS stays high for exactly RP_CYC cycles between them. memReady rises after the precharge of the last of these cycles, with both strobes high.
- R4: In every normal refresh, casN is low for exactly CSR_CYC cycles before rasN falls and stays low for exactly CHR_CYC cycles after that. rasN stays low for exactly RAS_CYC cycles. casN never falls while rasN is low.
- R5: The strobes move only while busGrant is high. refReq stays high from the request until the precharge after the cycle is complete. While busGrant stays low, no refresh cycle starts.
- R6: Once memReady is high, one refresh falls due every REF_INTERVAL_CYC cycles and is carried out.
- R7: Refreshes that fall due while the grant is withheld are queued as a debt and carried out once the grant returns. The debt stops growing at DEBT_MAX, and any refresh that falls due beyond that limit is lost.
- R8: When lpReq is high while memReady is high, the block clears the debt and lowers memReady. It drops casN CSR_CYC cycles before rasN. It then holds both strobes low for at least CHR_CYC + SREF_MIN_CYC cycles, and for as long as lpReq stays high.
- R9: On self-refresh exit, rasN and casN rise together and stay high for exactly RPS_CYC cycles. One normal refresh follows, and only after its precharge does memReady rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busGrant | input | 1 | Arbiter grant; high means the strobes belong to this block and RAS is precharged |
| lpReq | input | 1 | Low-power request; level held for the whole self-refresh |
| refReq | output | 1 | Bus request toward the arbiter |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low (both byte lanes together) |
| memReady | output | 1 | Memory initialized and available for accesses |

## Verification
The hardest state to reach is a saturated refresh debt. It needs the grant withheld for more than DEBT_MAX full refresh intervals. Once the grant returns, the number of refresh cycles must show that exactly the excess ticks were lost. The stimulus runs a scaled-down interval and blocks the arbiter in two windows: one of five intervals, which must be repaid in full, and one of twelve intervals, of which four must be lost. The window edges are set half an interval away from the expected ticks, so the cycle counts are exact. Self-refresh is then entered twice, once released before the minimum hold and once held well beyond it. This checks the exit precharge and the extra refresh before ready.

// File: rtl/refresh_seq_pkg.sv
package refresh_seq_pkg;

  localparam int TMR_W = 24;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_REQ,
    ST_CSR,
    ST_HOLD,
    ST_RASREST,
    ST_PRE,
    ST_SREF,
    ST_SREFPRE,
    ST_REL
  } seqStateT;

  typedef struct packed {
    logic             timerLoad;
    logic [TMR_W-1:0] timerVal;
    logic             tickEn;
    logic             debtDec;
    logic             debtClr;
    logic             burstDec;
  } seqStrobeT;

endpackage

// File: rtl/refresh_seq_dp.sv
module refresh_seq_dp
  import refresh_seq_pkg::*;
#(
  parameter int TIMER_RST        = 49999,
  parameter int INIT_REFRESHES   = 8,
  parameter int REF_INTERVAL_CYC = 3900,
  parameter int DEBT_MAX         = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  seqStrobeT strobe,
  output logic      timerZero,
  output logic      burstLast,
  output logic      debtPending
);

  localparam int IW = $clog2(REF_INTERVAL_CYC + 1);
  localparam int DW = $clog2(DEBT_MAX + 1);
  localparam int BW = $clog2(INIT_REFRESHES + 1);

  logic [TMR_W-1:0] phaseTimer;
  logic [IW-1:0]    intervalCnt;
  logic [DW-1:0]    debtCnt;
  logic [BW-1:0]    burstCnt;
  logic             refTick;

  // phase timer: loaded by the control, counts down to zero and rests there
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 phaseTimer <= TMR_W'(TIMER_RST);
    else if (strobe.timerLoad) phaseTimer <= strobe.timerVal;
    else if (phaseTimer != '0) phaseTimer <= phaseTimer - 1'b1;
  end
  assign timerZero = (phaseTimer == '0);

  // refresh interval timer
  assign refTick = strobe.tickEn && (intervalCnt == IW'(REF_INTERVAL_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               intervalCnt <= '0;
    else if (strobe.debtClr) intervalCnt <= '0;
    else if (refTick)        intervalCnt <= '0;
    else if (strobe.tickEn)  intervalCnt <= intervalCnt + 1'b1;
  end

  // refresh debt, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               debtCnt <= '0;
    else if (strobe.debtClr) debtCnt <= '0;
    else begin
      unique case ({refTick, strobe.debtDec})
        2'b10:   if (debtCnt != DW'(DEBT_MAX)) debtCnt <= debtCnt + 1'b1;
        2'b01:   if (debtCnt != '0) debtCnt <= debtCnt - 1'b1;
        default: debtCnt <= debtCnt;
      endcase
    end
  end
  assign debtPending = (debtCnt != '0);

  // power-up refresh burst counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                burstCnt <= BW'(INIT_REFRESHES);
    else if (strobe.burstDec && burstCnt != '0) burstCnt <= burstCnt - 1'b1;
  end
  assign burstLast = (burstCnt == BW'(1));

  // R7
  debt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    debtCnt <= DW'(DEBT_MAX));

  // R6
  debt_no_growth_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.tickEn |=> (debtCnt <= $past(debtCnt)));

endmodule

// File: rtl/refresh_seq_ctrl.sv
module refresh_seq_ctrl
  import refresh_seq_pkg::*;
#(
  parameter int CSR_CYC      = 3,
  parameter int CHR_CYC      = 3,
  parameter int RAS_CYC      = 15,
  parameter int RP_CYC       = 10,
  parameter int RPS_CYC      = 28,
  parameter int SREF_MIN_CYC = 25000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      busGrant,
  input  logic      lpReq,
  input  logic      timerZero,
  input  logic      burstLast,
  input  logic      debtPending,
  output seqStrobeT strobe,
  output logic      refReq,
  output logic      rasN,
  output logic      casN,
  output logic      memReady
);

  localparam int HW = $clog2(RP_CYC + 2);
  localparam int LW = $clog2(RAS_CYC + 2);

  seqStateT state, nextState;
  logic initDone, srefMode, exitPend;
  logic setInit, setReady, clrReady, setSref, clrSref, setExit, clrExit;

  always_comb begin
    nextState = state;
    strobe    = '0;
    strobe.tickEn = memReady;
    setInit  = 1'b0; setReady = 1'b0; clrReady = 1'b0;
    setSref  = 1'b0; clrSref  = 1'b0;
    setExit  = 1'b0; clrExit  = 1'b0;
    unique case (state)
      ST_PWRUP: if (timerZero) nextState = ST_REQ;
      ST_IDLE: begin
        if (lpReq) begin
          nextState      = ST_REQ;
          setSref        = 1'b1;
          clrReady       = 1'b1;
          strobe.debtClr = 1'b1;
        end else if (debtPending) begin
          nextState = ST_REQ;
        end
      end
      ST_REQ: if (busGrant) begin
        nextState        = ST_CSR;
        strobe.timerLoad = 1'b1;
        strobe.timerVal  = TMR_W'(CSR_CYC - 1);
      end
      ST_CSR: if (timerZero) begin
        nextState        = ST_HOLD;
        strobe.timerLoad = 1'b1;
        strobe.timerVal  = TMR_W'(CHR_CYC - 1);
      end
      ST_HOLD: if (timerZero) begin
        strobe.timerLoad = 1'b1;
        if (srefMode) begin
          nextState       = ST_SREF;
          strobe.timerVal = TMR_W'(SREF_MIN_CYC - 1);
        end else begin
          nextState       = ST_RASREST;
          strobe.timerVal = TMR_W'(RAS_CYC - CHR_CYC - 1);
        end
      end
      ST_RASREST: if (timerZero) begin
        nextState        = ST_PRE;
        strobe.timerLoad = 1'b1;
        strobe.timerVal  = TMR_W'(RP_CYC - 1);
      end
      ST_SREF: if (timerZero && !lpReq) begin
        nextState        = ST_SREFPRE;
        strobe.timerLoad = 1'b1;
        strobe.timerVal  = TMR_W'(RPS_CYC - 1);
      end
      ST_SREFPRE: if (timerZero) begin
        nextState        = ST_CSR;
        strobe.timerLoad = 1'b1;
        strobe.timerVal  = TMR_W'(CSR_CYC - 1);
        clrSref          = 1'b1;
        setExit          = 1'b1;
      end
      ST_PRE: if (timerZero) begin
        if (!initDone) begin
          strobe.burstDec = 1'b1;
          if (burstLast) begin
            nextState = ST_REL;
            setInit   = 1'b1;
            setReady  = 1'b1;
          end else begin
            nextState        = ST_CSR;
            strobe.timerLoad = 1'b1;
            strobe.timerVal  = TMR_W'(CSR_CYC - 1);
          end
        end else if (exitPend) begin
          nextState = ST_REL;
          setReady  = 1'b1;
          clrExit   = 1'b1;
        end else begin
          nextState      = ST_REL;
          strobe.debtDec = 1'b1;
        end
      end
      ST_REL: if (!busGrant) nextState = ST_IDLE;
      default: nextState = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_PWRUP;
      initDone <= 1'b0;
      memReady <= 1'b0;
      srefMode <= 1'b0;
      exitPend <= 1'b0;
      rasN     <= 1'b1;
      casN     <= 1'b1;
      refReq   <= 1'b0;
    end else begin
      state <= nextState;
      if (setInit) initDone <= 1'b1;
      if (setReady)      memReady <= 1'b1;
      else if (clrReady) memReady <= 1'b0;
      if (setSref)      srefMode <= 1'b1;
      else if (clrSref) srefMode <= 1'b0;
      if (setExit)      exitPend <= 1'b1;
      else if (clrExit) exitPend <= 1'b0;
      rasN   <= !(nextState inside {ST_HOLD, ST_RASREST, ST_SREF});
      casN   <= !(nextState inside {ST_CSR, ST_HOLD, ST_SREF});
      refReq <= nextState inside {ST_REQ, ST_CSR, ST_HOLD, ST_RASREST,
                                  ST_PRE, ST_SREF, ST_SREFPRE};
    end
  end

  // strobe width monitors used by the checks below
  logic [HW-1:0] rasHighCnt;
  logic [LW-1:0] rasLowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasHighCnt <= HW'(RP_CYC);
      rasLowCnt  <= '0;
    end else begin
      if (!rasN) rasHighCnt <= '0;
      else if (rasHighCnt != HW'(RP_CYC)) rasHighCnt <= rasHighCnt + 1'b1;
      if (rasN) rasLowCnt <= '0;
      else if (rasLowCnt != LW'(RAS_CYC)) rasLowCnt <= rasLowCnt + 1'b1;
    end
  end

  // R4
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> $past(!casN));

  // R4
  no_cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> rasN);

  // R4
  ras_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (rasLowCnt >= LW'(RAS_CYC)));

  // R3
  precharge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> (rasHighCnt >= HW'(RP_CYC)));

  // R5
  strobe_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN || !casN) |-> busGrant);

  // R5
  req_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(refReq) |-> (rasN && casN));

  // R8
  sref_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SREF && lpReq) |=> !rasN);

  // R3
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReady) |-> (rasN && casN));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import refresh_seq_pkg::*;
#(
  parameter int PWR_WAIT_CYC     = 50000,
  parameter int INIT_REFRESHES   = 8,
  parameter int REF_INTERVAL_CYC = 3900,
  parameter int CSR_CYC          = 3,
  parameter int CHR_CYC          = 3,
  parameter int RAS_CYC          = 15,
  parameter int RP_CYC           = 10,
  parameter int RPS_CYC          = 28,
  parameter int SREF_MIN_CYC     = 25000,
  parameter int DEBT_MAX         = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic busGrant,
  input  logic lpReq,
  output logic refReq,
  output logic rasN,
  output logic casN,
  output logic memReady
);

  seqStrobeT seqStrobe;
  logic      timerZero, burstLast, debtPending;

  refresh_seq_ctrl #(
    .CSR_CYC      (CSR_CYC),
    .CHR_CYC      (CHR_CYC),
    .RAS_CYC      (RAS_CYC),
    .RP_CYC       (RP_CYC),
    .RPS_CYC      (RPS_CYC),
    .SREF_MIN_CYC (SREF_MIN_CYC)
  ) ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busGrant    (busGrant),
    .lpReq       (lpReq),
    .timerZero   (timerZero),
    .burstLast   (burstLast),
    .debtPending (debtPending),
    .strobe      (seqStrobe),
    .refReq      (refReq),
    .rasN        (rasN),
    .casN        (casN),
    .memReady    (memReady)
  );

  refresh_seq_dp #(
    .TIMER_RST        (PWR_WAIT_CYC - 1),
    .INIT_REFRESHES   (INIT_REFRESHES),
    .REF_INTERVAL_CYC (REF_INTERVAL_CYC),
    .DEBT_MAX         (DEBT_MAX)
  ) dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (seqStrobe),
    .timerZero   (timerZero),
    .burstLast   (burstLast),
    .debtPending (debtPending)
  );

endmodule

// File: tb/tb_dram_refresh_seq.sv
`timescale 1ns/1ps
module tb_dram_refresh_seq;

  localparam int P_WAIT = 100;
  localparam int P_INIT = 8;
  localparam int P_INT  = 1000;
  localparam int P_CSR  = 3;
  localparam int P_CHR  = 3;
  localparam int P_RAS  = 15;
  localparam int P_RP   = 10;
  localparam int P_RPS  = 28;
  localparam int P_SREF = 300;
  localparam int P_DEBT = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busGrant = 1'b0;
  logic lpReq = 1'b0;
  logic refReq, rasN, casN, memReady;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .PWR_WAIT_CYC (P_WAIT), .INIT_REFRESHES (P_INIT), .REF_INTERVAL_CYC (P_INT),
    .CSR_CYC (P_CSR), .CHR_CYC (P_CHR), .RAS_CYC (P_RAS), .RP_CYC (P_RP),
    .RPS_CYC (P_RPS), .SREF_MIN_CYC (P_SREF), .DEBT_MAX (P_DEBT)
  ) dut (
    .clk (clk), .rstN (rstN), .busGrant (busGrant), .lpReq (lpReq),
    .refReq (refReq), .rasN (rasN), .casN (casN), .memReady (memReady)
  );

  typedef struct {
    int    lead;
    int    width;
    int    hold;
    int    gap;
    bit    atLeast;
    string tag;
  } pulseT;

  pulseT expQ[$];
  int    checks = 0;
  int    fails = 0;
  int    pulses = 0;
  bit    allowGrant = 1'b0;
  bit    finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pushPulse(input int lead, input int width, input int hold,
                           input int gap, input bit atLeast, input string tag);
    pulseT p;
    p.lead = lead; p.width = width; p.hold = hold;
    p.gap = gap; p.atLeast = atLeast; p.tag = tag;
    expQ.push_back(p);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // arbiter model: grants while the request is up and access traffic allows
  initial forever begin
    @(negedge clk);
    busGrant = refReq && allowGrant;
  end

  // monitor: measures every RAS pulse and compares with the expected queue
  initial begin
    int lead = 0, width = 0, hold = 0, gapCnt = 0, gapCap = -1;
    bit prevRas = 1'b1, prevCas = 1'b1;
    pulseT e;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (rasN) begin
          if (!prevRas) begin
            pulses++;
            if (expQ.size() == 0) begin
              check(1'b0, "R5", "unexpected refresh pulse", pulses, 0);
            end else begin
              e = expQ.pop_front();
              check(lead == e.lead, e.tag, "CAS lead before RAS", lead, e.lead);
              if (e.atLeast) begin
                check(width >= e.width, e.tag, "RAS low width (min)", width, e.width);
                check(hold >= e.hold, e.tag, "CAS low after RAS fall (min)", hold, e.hold);
              end else begin
                check(width == e.width, e.tag, "RAS low width", width, e.width);
                check(hold == e.hold, e.tag, "CAS low after RAS fall", hold, e.hold);
              end
              if (e.gap >= 0)
                check(gapCap == e.gap, e.tag, "RAS precharge before CAS fall", gapCap, e.gap);
            end
          end
          if (casN) begin
            gapCnt++;
            lead = 0;
          end else begin
            if (prevCas) gapCap = gapCnt;
            lead++;
            gapCnt = 0;
          end
        end else begin
          if (prevRas) begin
            width = 0;
            hold = 0;
          end
          width++;
          if (!casN) hold++;
          gapCnt = 0;
        end
        prevRas = rasN;
        prevCas = casN;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(negedge clk);
    if (!finished) begin
      check(1'b0, "R5", "watchdog expired", 0, 1);
      finishRun();
    end
  end

  // driver
  initial begin
    int n;
    int base;
    waitCycles(3);
    // R1 reset state
    check(rasN == 1'b1, "R1", "rasN in reset", rasN, 1);
    check(casN == 1'b1, "R1", "casN in reset", casN, 1);
    check(refReq == 1'b0, "R1", "refReq in reset", refReq, 0);
    check(memReady == 1'b0, "R1", "memReady in reset", memReady, 0);
    rstN = 1'b1;
    allowGrant = 1'b1;

    for (int i = 0; i < P_INIT; i++)
      pushPulse(P_CSR, P_RAS, P_CHR, (i == 0) ? -1 : P_RP, 1'b0, "R3");

    // R2 power-up pause
    n = 0;
    while (!refReq && n < 1000) begin
      @(negedge clk);
      n++;
      if (!refReq) check(casN && rasN, "R2", "strobes idle during pause", casN, 1);
    end
    check(n == P_WAIT, "R2", "cycles until first request", n, P_WAIT);

    // R3 ready after the burst
    n = 0;
    while (!memReady && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(pulses == P_INIT, "R3", "refreshes before ready", pulses, P_INIT);
    check(expQ.size() == 0, "R3", "pending init pulses", expQ.size(), 0);
    base = pulses;

    // R6 steady refresh rate
    pushPulse(P_CSR, P_RAS, P_CHR, -1, 1'b0, "R6");
    pushPulse(P_CSR, P_RAS, P_CHR, -1, 1'b0, "R6");
    waitCycles(P_INT * 5 / 2);
    check(pulses == base + 2, "R6", "refreshes in 2.5 intervals", pulses, base + 2);

    // R5/R7 short block: five ticks owed, all repaid
    allowGrant = 1'b0;
    for (int i = 0; i < 6; i++) pushPulse(P_CSR, P_RAS, P_CHR, -1, 1'b0, "R7");
    waitCycles(P_INT * 5);
    check(pulses == base + 2, "R5", "no refresh while grant withheld", pulses, base + 2);
    check(refReq == 1'b1, "R5", "request held while waiting", refReq, 1);
    allowGrant = 1'b1;
    waitCycles(P_INT);
    check(pulses == base + 8, "R7", "debt repaid", pulses, base + 8);

    // R7 long block: twelve ticks owed, debt capped, four lost
    allowGrant = 1'b0;
    waitCycles(P_INT * 12);
    check(pulses == base + 8, "R5", "no refresh during long block", pulses, base + 8);
    check(memReady == 1'b1, "R6", "ready held during block", memReady, 1);
    allowGrant = 1'b1;
    for (int i = 0; i < P_DEBT + 3; i++) pushPulse(P_CSR, P_RAS, P_CHR, -1, 1'b0, "R7");
    waitCycles(P_INT * 3);
    check(pulses == base + 19, "R7", "refreshes after saturation", pulses, base + 19);
    check(expQ.size() == 0, "R7", "pending pulses", expQ.size(), 0);

    // R8/R9 self-refresh released before the minimum hold
    base = pulses;
    pushPulse(P_CSR, P_CHR + P_SREF, P_CHR + P_SREF, -1, 1'b0, "R8");
    pushPulse(P_CSR, P_RAS, P_CHR, P_RPS, 1'b0, "R9");
    lpReq = 1'b1;
    n = 0;
    while (rasN && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(memReady == 1'b0, "R8", "ready low in self-refresh", memReady, 0);
    waitCycles(50);
    lpReq = 1'b0;
    check(rasN == 1'b0, "R8", "RAS held for minimum", rasN, 0);
    n = 0;
    while (!memReady && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(pulses == base + 2, "R9", "extra refresh before ready", pulses, base + 2);

    // R8/R9 self-refresh held past the minimum
    base = pulses;
    pushPulse(P_CSR, 600, 600, -1, 1'b1, "R8");
    pushPulse(P_CSR, P_RAS, P_CHR, P_RPS, 1'b0, "R9");
    lpReq = 1'b1;
    n = 0;
    while (rasN && n < 200) begin
      @(negedge clk);
      n++;
    end
    waitCycles(600);
    check(rasN == 1'b0, "R8", "RAS held while request high", rasN, 0);
    check(casN == 1'b0, "R8", "CAS held while request high", casN, 0);
    lpReq = 1'b0;
    n = 0;
    while (!memReady && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(pulses == base + 2, "R9", "extra refresh after long hold", pulses, base + 2);
    check(expQ.size() == 0, "R9", "pending pulses", expQ.size(), 0);

    finished = 1'b1;
    finishRun();
  end

endmodule